// File: doc/BRIEF.md
# UART Receive Character Queue with Line Status

This block sits between the receive shift register of a UART and the CPU. The shift register presents each assembled character with a one-bit tag that says the character's parity bit was wrong. Characters go into a 16-entry queue, and the CPU takes them from a data-read port in arrival order.

A three-bit status word is kept alongside the queue. Bit 0 shows that unread data is waiting. Bit 1 latches an overrun, which happens when a character arrives while the queue is full. Bit 2 latches a parity error, and it is tied to the character at the head of the queue rather than to the newest arrival.

Bits 1 and 2 are sticky and clear when the CPU reads the status word. A new event in the same cycle as that read still wins, so no event is lost.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, statusWord is 0 and rdData is 0.
- R2: statusWord bit 0 is 1 exactly when the queue holds one or more unread characters. It changes on the clock edge that accepts a push or performs a pop.
- R3: Characters come out in arrival order. rdData shows the head character while dataRd is high, and the pop happens at that clock edge.
- R4: A push that arrives while 16 characters are held is dropped, and the held characters are unchanged. This holds even if dataRd is high in the same cycle. statusWord bit 1 becomes 1 at that edge.
- R5: statusWord bit 1 stays 1 until a cycle with statusRd high, and it is 0 after that edge.
- R6: statusWord bit 2 becomes 1 at the edge where a tagged character becomes the queue head, either pushed into an empty queue or exposed by a pop. It stays 1 after that character is popped.
- R7: A cycle with statusRd high clears statusWord bit 2. A tagged character that is not at the head does not set it.
- R8: When statusRd is high in the same cycle as an overrun or a tagged head arrival, the matching flag is 1 after the edge.
- R9: A data read on an empty queue gives rdData 0 and changes nothing. A later push is then read back correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | The shift register presents a character this cycle |
| pushData | input | 8 | Assembled character |
| pushParErr | input | 1 | Parity-error tag of the character |
| dataRd | input | 1 | CPU reads (pops) the data register |
| rdData | output | 8 | Head character, or 0 when the queue is empty |
| statusRd | input | 1 | CPU reads the status word (clears bits 1 and 2) |
| statusWord | output | 3 | {parity error, overrun, data ready} |

## Verification
The assertions take it that each input strobe is a single-cycle level sampled at the rising edge. They also take it that a push is meant to be lost whenever the queue is full at that edge, even if a pop happens in the same cycle. The bench drives every strobe on the falling edge and holds it for exactly one cycle. It only ever combines a pop with a push against a full queue, and a status read with a set event, in the cycles built to test those two corners.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
  } rxs_strobe_t;
endpackage

// File: rtl/rxs_datapath.sv
module rxs_datapath
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rxs_strobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrTag,
  output logic [DATA_W-1:0] headData,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic              headNew,
  output logic              headTag,
  output logic [AW:0]       level
);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [DEPTH-1:0]  tagMem;
  logic [AW-1:0]     wrPtr, rdPtr, nextRd;

  assign nextRd    = rdPtr + 1'b1;
  assign fifoEmpty = (level == '0);
  assign fifoFull  = (level == FULL_LVL);
  assign headData  = fifoEmpty ? '0 : dataMem[rdPtr];

  // one write-enabled slot per entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.push && wrPtr == AW'(i)) begin
        dataMem[i] <= wrData;
        tagMem[i]  <= wrTag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= nextRd;
      case ({strobe.push, strobe.pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // which entry (if any) becomes the new head at this edge
  always_comb begin
    headNew = 1'b0;
    headTag = 1'b0;
    if (fifoEmpty || (strobe.pop && level == (AW+1)'(1))) begin
      headNew = strobe.push;
      headTag = wrTag;
    end else if (strobe.pop) begin
      headNew = 1'b1;
      headTag = tagMem[nextRd];
    end
  end
endmodule

// File: rtl/rxs_control.sv
module rxs_control
  import rxs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pushValid,
  input  logic        dataRd,
  input  logic        statusRd,
  input  logic        fifoEmpty,
  input  logic        fifoFull,
  input  logic        headNew,
  input  logic        headTag,
  output rxs_strobe_t strobe,
  output logic        ovrFlag,
  output logic        parFlag
);
  logic ovrSet, parSet;

  assign strobe.push = pushValid && !fifoFull;
  assign strobe.pop  = dataRd && !fifoEmpty;
  assign ovrSet      = pushValid && fifoFull;
  assign parSet      = headNew && headTag;

  // set beats clear-on-read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovrFlag <= 1'b0;
      parFlag <= 1'b0;
    end else begin
      if (ovrSet)        ovrFlag <= 1'b1;
      else if (statusRd) ovrFlag <= 1'b0;
      if (parSet)        parFlag <= 1'b1;
      else if (statusRd) parFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pushParErr,
  input  logic              dataRd,
  output logic [DATA_W-1:0] rdData,
  input  logic              statusRd,
  output logic [2:0]        statusWord
);
  localparam int AW = $clog2(DEPTH);

  rxs_strobe_t strobe;
  logic fifoEmpty, fifoFull, headNew, headTag, ovrFlag, parFlag;
  logic [AW:0] level;

  rxs_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrData(pushData),
    .wrTag(pushParErr), .headData(rdData), .fifoEmpty(fifoEmpty),
    .fifoFull(fifoFull), .headNew(headNew), .headTag(headTag), .level(level)
  );

  rxs_control u_ctl (
    .clk(clk), .rst_n(rst_n), .pushValid(pushValid), .dataRd(dataRd),
    .statusRd(statusRd), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull),
    .headNew(headNew), .headTag(headTag), .strobe(strobe),
    .ovrFlag(ovrFlag), .parFlag(parFlag)
  );

  assign statusWord = {parFlag, ovrFlag, !fifoEmpty};
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker #(
  parameter int DATA_W = 8,
  parameter int LW     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pushValid,
  input logic              dataRd,
  input logic              statusRd,
  input logic [DATA_W-1:0] rdData,
  input logic [2:0]        statusWord,
  input logic              fifoFull,
  input logic              parArrive,
  input logic [LW-1:0]     level
);
  // R2
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!statusWord[0] && pushValid) |=> statusWord[0]);
  // R4
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pushValid && fifoFull) |=> statusWord[1]);
  // R4
  overrun_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pushValid && fifoFull && !dataRd) |=> $stable(level));
  // R5
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (statusRd && !(pushValid && fifoFull)) |=> !statusWord[1]);
  // R6
  parity_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parArrive |=> statusWord[2]);
  // R7
  parity_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (statusRd && !parArrive) |=> !statusWord[2]);
  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !statusWord[0] |-> (rdData == '0));
endmodule

bind uart_rx_status rxs_checker #(.DATA_W(DATA_W), .LW($clog2(DEPTH)+1)) u_chk (
  .clk(clk), .rst_n(rst_n), .pushValid(pushValid), .dataRd(dataRd),
  .statusRd(statusRd), .rdData(rdData), .statusWord(statusWord),
  .fifoFull(fifoFull), .parArrive(headNew && headTag), .level(level)
);

// File: tb/uart_rx_status_test.sv
module uart_rx_status_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pushValid = 1'b0, pushParErr = 1'b0, dataRd = 1'b0, statusRd = 1'b0;
  logic [7:0] pushData = '0;
  logic [7:0] rdData;
  logic [2:0] statusWord;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  uart_rx_status uut (
    .clk(clk), .rst_n(rst_n), .pushValid(pushValid), .pushData(pushData),
    .pushParErr(pushParErr), .dataRd(dataRd), .rdData(rdData),
    .statusRd(statusRd), .statusWord(statusWord)
  );

  always #4 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle from a falling edge to the next
  task automatic step(logic pv, logic [7:0] d, logic p, logic dr, logic sr);
    pushValid = pv; pushData = d; pushParErr = p; dataRd = dr; statusRd = sr;
    @(negedge clk);
    pushValid = 0; pushData = 0; pushParErr = 0; dataRd = 0; statusRd = 0;
  endtask

  task automatic push(logic [7:0] d, logic p);
    step(1'b1, d, p, 1'b0, 1'b0);
  endtask

  task automatic readExp(string req, logic [7:0] exp);
    check(req, rdData, exp);
    step(1'b0, 8'h0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic statRead();
    step(1'b0, 8'h0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_order();
    push(8'hA1, 0); check("R2", 8'(statusWord[0]), 8'h1);
    push(8'hB2, 0); push(8'hC3, 0);
    readExp("R3", 8'hA1); readExp("R3", 8'hB2);
    check("R2", 8'(statusWord[0]), 8'h1);
    readExp("R3", 8'hC3);
    check("R2", 8'(statusWord[0]), 8'h0);
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 16; i++) push(8'(i * 7 + 1), 0);
    check("R4", 8'(statusWord[1]), 8'h0);
    push(8'hEE, 0);
    check("R4", 8'(statusWord[1]), 8'h1);
    step(0, 0, 0, 0, 0);
    check("R5", 8'(statusWord[1]), 8'h1);
    for (int i = 0; i < 16; i++) readExp("R4", 8'(i * 7 + 1));
    check("R4", 8'(statusWord[0]), 8'h0);
    statRead();
    check("R5", 8'(statusWord[1]), 8'h0);
  endtask

  task automatic t_overrun_pop();
    for (int i = 0; i < 16; i++) push(8'(8'h80 + i), 0);
    step(1'b1, 8'h33, 1'b0, 1'b1, 1'b0);
    check("R4", 8'(statusWord[1]), 8'h1);
    for (int i = 1; i < 16; i++) readExp("R4", 8'(8'h80 + i));
    check("R4", 8'(statusWord[0]), 8'h0);
    statRead();
  endtask

  task automatic t_parity();
    push(8'h11, 0); push(8'h22, 1);
    check("R7", 8'(statusWord[2]), 8'h0);
    readExp("R3", 8'h11);
    check("R6", 8'(statusWord[2]), 8'h1);
    readExp("R3", 8'h22);
    check("R6", 8'(statusWord[2]), 8'h1);
    statRead();
    check("R7", 8'(statusWord[2]), 8'h0);
    push(8'h44, 1);
    check("R6", 8'(statusWord[2]), 8'h1);
    statRead();
    check("R7", 8'(statusWord[2]), 8'h0);
    readExp("R3", 8'h44);
  endtask

  task automatic t_priority();
    step(1'b1, 8'h55, 1'b1, 1'b0, 1'b1);
    check("R8", 8'(statusWord[2]), 8'h1);
    readExp("R8", 8'h55);
    statRead();
    for (int i = 0; i < 16; i++) push(8'(i), 0);
    step(1'b1, 8'h66, 1'b0, 1'b0, 1'b1);
    check("R8", 8'(statusWord[1]), 8'h1);
    for (int i = 0; i < 16; i++) readExp("R8", 8'(i));
    statRead();
    check("R8", 8'(statusWord), 8'h0);
  endtask

  task automatic t_empty_read();
    check("R9", rdData, 8'h0);
    step(1'b0, 8'h0, 1'b0, 1'b1, 1'b0);
    check("R9", 8'(statusWord), 8'h0);
    check("R9", rdData, 8'h0);
    push(8'h5A, 0);
    readExp("R9", 8'h5A);
    check("R9", 8'(statusWord[0]), 8'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 8'(statusWord), 8'h0);
    check("R1", rdData, 8'h0);
    rst_n = 1'b1;
    @(negedge clk);
    t_order();
    t_overrun();
    t_overrun_pop();
    t_parity();
    t_priority();
    t_empty_read();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule